// File: doc/BRIEF.md
# Bit-Serial Reduction and Broadcast Tree

This block is a binary tree of small switching nodes that moves words between one root port and a power-of-two number of leaf ports, one bit per clock. Each link carries a valid flag, a word-start marker and a data bit. A shared two-bit mode input sets what the tree does for the current operation. It can copy a stream from the root to every leaf. It can also bring one leaf's stream to the root, add all leaf words, or pick the smallest leaf word.

No node ever holds a whole word. Each node registers the bit it forwards and keeps at most a carry bit, an "inputs still equal" bit and a lock bit. The first result bit therefore reaches the far end after one cycle per tree level, and the rest follow one per cycle. Addition needs the least significant bit first. Minimum needs the most significant bit first. A leaf flag taken as a one-bit word turns the sum into a population count.

The host holds the mode stable for the whole operation and changes it only while the tree is idle.

Top module: `serial_tree`

## Requirements
- R1: After a synchronous active-low reset, root_up_valid and every leaf_down_valid read 0 until stimulus arrives.
- R2: With mode 0 (broadcast), each valid/first/bit triple on the root-down port appears unchanged on every leaf-down port exactly LEVELS = log2(LEAVES) cycles later. Leaf-up traffic is ignored and root_up_valid stays 0.
- R3: In any mode other than 0, the root-down input is ignored and all leaf_down_valid bits stay 0.
- R4: With mode 1 (select), at most one leaf drives valid. Its stream appears unchanged at the root LEVELS cycles later, including the first marker. With no valid leaf, the root stays invalid.
- R5: With mode 2 (sum), every active leaf starts a W-bit word in the same cycle, least significant bit first. The root then emits the exact sum as W+LEVELS bits, LSB first, starting LEVELS cycles after the leaf start. An idle leaf counts as zero.
- R6: In mode 2 with one-bit leaf words, the root emits the number of leaves whose flag is 1, as LEVELS+1 bits, LSB first.
- R7: The word-start marker clears the carry. Sum words separated by LEVELS idle leaf cycles produce independent, back-to-back root words.
- R8: With mode 3 (minimum), active leaves send W-bit words most significant bit first. The root emits the smallest of them, W bits MSB first, LEVELS cycles later.
- R9: In mode 3 an idle leaf acts as larger than any value. Equal words keep the comparison open until a bit differs, so ties give the common value.
- R10: root_up_first is high exactly on the first bit of each root word and never without root_up_valid. The same holds for each leaf-down port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 broadcast, 1 select, 2 sum, 3 minimum |
| root_down_valid | input | 1 | Root-down bit present |
| root_down_first | input | 1 | Root-down bit starts a word |
| root_down_bit | input | 1 | Root-down data bit |
| root_up_valid | output | 1 | Root-up bit present |
| root_up_first | output | 1 | Root-up bit starts a word |
| root_up_bit | output | 1 | Root-up data bit |
| leaf_up_valid | input | LEAVES | Per-leaf up bit present |
| leaf_up_first | input | LEAVES | Per-leaf up bit starts a word |
| leaf_up_bit | input | LEAVES | Per-leaf up data bit |
| leaf_down_valid | output | LEAVES | Per-leaf down bit present |
| leaf_down_first | output | LEAVES | Per-leaf down bit starts a word |
| leaf_down_bit | output | LEAVES | Per-leaf down data bit |

## Verification
The bench drives sums whose carry ripples into the added top bits, for example all leaves at 255. A node that dropped its trailing carry cycle would truncate the root word, and one that sized the tail wrongly would shift it. It also sends two sum words with the minimum idle gap between them, where a carry not cleared by the start marker would corrupt the second word.

For minimum, it uses words that match on a long MSB prefix, exact ties and partly idle leaf sets. A node that locked too early would pick the wrong word, and one that treated an idle child as zero would return 0.

Mode gating is probed by driving the port that the current mode should ignore. Any leak shows up as a valid bit on an output that should stay quiet.

// File: rtl/serial_tree_pkg.sv
// Shared definitions for the bit-serial tree: the operation mode encoding.
package serial_tree_pkg;
    typedef enum logic [1:0] {
        MODE_DOWN   = 2'd0,
        MODE_SELECT = 2'd1,
        MODE_SUM    = 2'd2,
        MODE_MIN    = 2'd3
    } tree_mode_e;
endpackage

// File: rtl/tree_down_node.sv
// Downward stage of one tree node: registers the bit from the parent once.
// The parent level fans the registered copy out to both children.
// Assumes: en is high only in broadcast mode. When en is low, no valid bit
// leaves this stage.
module tree_down_node (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic i_v,
    input  logic i_f,
    input  logic i_b,
    output logic o_v,
    output logic o_f,
    output logic o_b
);
    // Purpose: one-cycle registered copy of the parent stream, gated by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_v <= 1'b0;
            o_f <= 1'b0;
            o_b <= 1'b0;
        end else begin
            o_v <= en & i_v;
            o_f <= en & i_v & i_f;
            o_b <= i_b;
        end
    end
endmodule

// File: rtl/tree_up_node.sv
// Upward stage of one tree node: merges two child bit streams into one
// registered parent stream, according to the mode.
//  select: forwards whichever child is valid.
//  sum   : serial add, LSB first. Adds one trailing carry cycle per word.
//  min   : serial minimum, MSB first. Locks onto the first child to show a 0
//          where the other shows a 1.
// Assumes: the two children of one node are word-aligned. An idle child
// drives valid 0 (zero for sum, "infinitely large" for min).
module tree_up_node
    import serial_tree_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tree_mode_e mode,
    input  logic       a_v,
    input  logic       a_f,
    input  logic       a_b,
    input  logic       b_v,
    input  logic       b_f,
    input  logic       b_b,
    output logic       o_v,
    output logic       o_f,
    output logic       o_b
);
    logic carry_q, act_q, eq_q, pick_q;
    logic any_v, head, op_a, op_b, cin;
    logic nxt_v, nxt_f, nxt_b, nxt_carry, nxt_eq, nxt_pick, nxt_act;

    // Purpose: next output bit and next carry/compare state for this cycle.
    always_comb begin
        any_v     = a_v | b_v;
        head      = (a_v & a_f) | (b_v & b_f);
        op_a      = a_v & a_b;
        op_b      = b_v & b_b;
        cin       = head ? 1'b0 : carry_q;
        nxt_v     = 1'b0;
        nxt_f     = 1'b0;
        nxt_b     = 1'b0;
        nxt_carry = carry_q;
        nxt_eq    = eq_q;
        nxt_pick  = pick_q;
        nxt_act   = 1'b0;
        case (mode)
            MODE_SELECT: begin
                nxt_v = any_v;
                nxt_f = head;
                nxt_b = a_v ? a_b : b_b;
            end
            MODE_SUM: begin
                nxt_act = any_v;
                if (any_v) begin
                    nxt_v     = 1'b1;
                    nxt_f     = head;
                    nxt_b     = op_a ^ op_b ^ cin;
                    nxt_carry = (op_a & op_b) | (cin & (op_a ^ op_b));
                end else if (act_q) begin
                    nxt_v     = 1'b1;
                    nxt_b     = carry_q;
                    nxt_carry = 1'b0;
                end
            end
            MODE_MIN: begin
                nxt_v = any_v;
                nxt_f = head;
                if (a_v & b_v) begin
                    if (head | eq_q) begin
                        nxt_b    = a_b & b_b;
                        nxt_eq   = (a_b == b_b);
                        nxt_pick = a_b;
                    end else begin
                        nxt_b = pick_q ? b_b : a_b;
                    end
                end else begin
                    nxt_b = a_v ? a_b : b_b;
                end
            end
            default: begin
                nxt_v = 1'b0;
            end
        endcase
    end

    // Purpose: register the merged stream and the per-word state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_v     <= 1'b0;
            o_f     <= 1'b0;
            o_b     <= 1'b0;
            carry_q <= 1'b0;
            act_q   <= 1'b0;
            eq_q    <= 1'b0;
            pick_q  <= 1'b0;
        end else begin
            o_v     <= nxt_v;
            o_f     <= nxt_f;
            o_b     <= nxt_b;
            carry_q <= nxt_carry;
            act_q   <= nxt_act;
            eq_q    <= nxt_eq;
            pick_q  <= nxt_pick;
        end
    end
endmodule

// File: rtl/serial_tree.sv
// Complete binary tree of LEAVES-1 nodes in heap order. Node n has children
// 2n and 2n+1, and leaf i sits at index LEAVES+i. Every node adds one
// register in each direction, so the latency is LEVELS cycles each way.
// Assumes: LEAVES is a power of two of at least 2, and the mode changes only
// while the tree is idle.
module serial_tree
    import serial_tree_pkg::*;
#(
    parameter int LEAVES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              root_down_valid,
    input  logic              root_down_first,
    input  logic              root_down_bit,
    output logic              root_up_valid,
    output logic              root_up_first,
    output logic              root_up_bit,
    input  logic [LEAVES-1:0] leaf_up_valid,
    input  logic [LEAVES-1:0] leaf_up_first,
    input  logic [LEAVES-1:0] leaf_up_bit,
    output logic [LEAVES-1:0] leaf_down_valid,
    output logic [LEAVES-1:0] leaf_down_first,
    output logic [LEAVES-1:0] leaf_down_bit
);
    localparam int SLOTS = 2 * LEAVES;

    tree_mode_e          mode_e;
    logic                down_en;
    logic [SLOTS-1:1]    up_v, up_f, up_b;
    logic [SLOTS-1:1]    dn_v, dn_f, dn_b;

    assign mode_e  = tree_mode_e'(mode);
    assign down_en = (mode_e == MODE_DOWN);

    assign dn_v[1] = root_down_valid;
    assign dn_f[1] = root_down_first;
    assign dn_b[1] = root_down_bit;
    assign root_up_valid = up_v[1];
    assign root_up_first = up_f[1];
    assign root_up_bit   = up_b[1];

    // Leaf attachment: leaf i uses heap slot LEAVES+i.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        assign up_v[LEAVES+i]     = leaf_up_valid[i];
        assign up_f[LEAVES+i]     = leaf_up_first[i];
        assign up_b[LEAVES+i]     = leaf_up_bit[i];
        assign leaf_down_valid[i] = dn_v[LEAVES+i];
        assign leaf_down_first[i] = dn_f[LEAVES+i];
        assign leaf_down_bit[i]   = dn_b[LEAVES+i];
    end

    // Internal nodes: one upward merge and one downward copy stage each.
    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic d_v, d_f, d_b;

        tree_up_node up_i (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode_e),
            .a_v   (up_v[2*n]),
            .a_f   (up_f[2*n]),
            .a_b   (up_b[2*n]),
            .b_v   (up_v[2*n+1]),
            .b_f   (up_f[2*n+1]),
            .b_b   (up_b[2*n+1]),
            .o_v   (up_v[n]),
            .o_f   (up_f[n]),
            .o_b   (up_b[n])
        );

        tree_down_node down_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (down_en),
            .i_v   (dn_v[n]),
            .i_f   (dn_f[n]),
            .i_b   (dn_b[n]),
            .o_v   (d_v),
            .o_f   (d_f),
            .o_b   (d_b)
        );

        assign dn_v[2*n]   = d_v;
        assign dn_f[2*n]   = d_f;
        assign dn_b[2*n]   = d_b;
        assign dn_v[2*n+1] = d_v;
        assign dn_f[2*n+1] = d_f;
        assign dn_b[2*n+1] = d_b;
    end
endmodule

// File: rtl/serial_tree_chk.sv
// Protocol and mode-gating checks for serial_tree, attached by bind.
module serial_tree_chk
    import serial_tree_pkg::*;
#(
    parameter int LEAVES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              root_up_valid,
    input logic              root_up_first,
    input logic [LEAVES-1:0] leaf_up_valid,
    input logic [LEAVES-1:0] leaf_down_valid,
    input logic [LEAVES-1:0] leaf_down_first
);
    // R2: in broadcast mode nothing reaches the root-up port
    assert_up_quiet_in_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN) |=> !root_up_valid);

    // R3: outside broadcast mode no leaf-down bit is valid
    assert_down_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_DOWN) |=> (leaf_down_valid == '0));

    // R2: all leaves see the same broadcast bit in the same cycle
    assert_down_all_or_none_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (leaf_down_valid == '0) || (leaf_down_valid == '1));

    // R4: select mode carries at most one valid leaf
    assert_single_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SELECT) |-> $onehot0(leaf_up_valid));

    // R10: start marker never appears without valid, upward
    assert_root_first_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        root_up_first |-> root_up_valid);

    // R10: start marker never appears without valid, downward
    assert_leaf_first_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (leaf_down_first & ~leaf_down_valid) == '0);
endmodule

bind serial_tree serial_tree_chk #(.LEAVES(LEAVES)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode            (mode),
    .root_up_valid   (root_up_valid),
    .root_up_first   (root_up_first),
    .leaf_up_valid   (leaf_up_valid),
    .leaf_down_valid (leaf_down_valid),
    .leaf_down_first (leaf_down_first)
);

// File: tb/serial_tree_tb_top.sv
module serial_tree_tb_top;
    localparam int LEAVES = 8;
    localparam int LEVELS = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              root_down_valid = 1'b0, root_down_first = 1'b0, root_down_bit = 1'b0;
    logic              root_up_valid, root_up_first, root_up_bit;
    logic [LEAVES-1:0] leaf_up_valid = '0, leaf_up_first = '0, leaf_up_bit = '0;
    logic [LEAVES-1:0] leaf_down_valid, leaf_down_first, leaf_down_bit;

    serial_tree #(.LEAVES(LEAVES)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .root_down_valid(root_down_valid), .root_down_first(root_down_first),
        .root_down_bit(root_down_bit),
        .root_up_valid(root_up_valid), .root_up_first(root_up_first),
        .root_up_bit(root_up_bit),
        .leaf_up_valid(leaf_up_valid), .leaf_up_first(leaf_up_first),
        .leaf_up_bit(leaf_up_bit),
        .leaf_down_valid(leaf_down_valid), .leaf_down_first(leaf_down_first),
        .leaf_down_bit(leaf_down_bit)
    );

    always #5 clk = ~clk;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string idle_tag = "R1";

    // Reference model: expected stream per cycle, keyed by cycle number
    bit    eu_v[int], eu_f[int], eu_b[int];
    string eu_r[int];
    bit    ed_v[int], ed_f[int], ed_b[int];
    string ed_r[int];

    int unsigned vals [LEAVES];
    bit          act  [LEAVES];

    always @(posedge clk) cyc <= cyc + 1;

    // Compare every output on every cycle against the model
    always @(negedge clk) begin
        if (checking && !done) begin
            bit xv, xf, xb;
            string tg;
            xv = eu_v.exists(cyc) ? eu_v[cyc] : 1'b0;
            xf = eu_f.exists(cyc) ? eu_f[cyc] : 1'b0;
            xb = eu_b.exists(cyc) ? eu_b[cyc] : 1'b0;
            tg = eu_r.exists(cyc) ? eu_r[cyc] : idle_tag;
            n_vec++;
            if (root_up_valid !== xv || (xv && (root_up_first !== xf || root_up_bit !== xb))) begin
                n_bad++;
                $display("FAIL %s cycle %0d root up v/f/b=%b%b%b expected %b%b%b",
                         tg, cyc, root_up_valid, root_up_first, root_up_bit, xv, xf, xb);
            end
            xv = ed_v.exists(cyc) ? ed_v[cyc] : 1'b0;
            xf = ed_f.exists(cyc) ? ed_f[cyc] : 1'b0;
            xb = ed_b.exists(cyc) ? ed_b[cyc] : 1'b0;
            tg = ed_r.exists(cyc) ? ed_r[cyc] : idle_tag;
            n_vec++;
            if (leaf_down_valid !== {LEAVES{xv}} ||
                (xv && (leaf_down_first !== {LEAVES{xf}} || leaf_down_bit !== {LEAVES{xb}}))) begin
                n_bad++;
                $display("FAIL %s cycle %0d leaf down v=%b f=%b b=%b expected all %b%b%b",
                         tg, cyc, leaf_down_valid, leaf_down_first, leaf_down_bit, xv, xf, xb);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        if (cyc == 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
    endtask

    task automatic clear_leaves();
        for (int i = 0; i < LEAVES; i++) begin
            vals[i] = 0;
            act[i]  = 1'b0;
        end
    endtask

    // Send one word from the active leaves and post the expected root stream
    task automatic send_up(input int w, input int gap, input string tag);
        int  c0;
        longint unsigned total;
        int unsigned mn;
        int  nact;
        bit  msb;
        total = 0;
        mn    = 32'hFFFF_FFFF;
        nact  = 0;
        msb   = (mode == 2'd3);
        for (int i = 0; i < LEAVES; i++) begin
            if (act[i]) begin
                nact++;
                total += vals[i];
                if (vals[i] < mn) mn = vals[i];
            end
        end
        @(negedge clk);
        c0 = cyc;
        if (nact > 0) begin
            if (mode == 2'd1) begin
                for (int i = 0; i < LEAVES; i++) begin
                    if (act[i]) begin
                        for (int k = 0; k < w; k++) begin
                            eu_v[c0+LEVELS+k] = 1'b1;
                            eu_f[c0+LEVELS+k] = (k == 0);
                            eu_b[c0+LEVELS+k] = vals[i][k];
                            eu_r[c0+LEVELS+k] = tag;
                        end
                    end
                end
            end else if (mode == 2'd2) begin
                for (int k = 0; k < w + LEVELS; k++) begin
                    eu_v[c0+LEVELS+k] = 1'b1;
                    eu_f[c0+LEVELS+k] = (k == 0);
                    eu_b[c0+LEVELS+k] = total[k];
                    eu_r[c0+LEVELS+k] = tag;
                end
            end else if (mode == 2'd3) begin
                for (int k = 0; k < w; k++) begin
                    eu_v[c0+LEVELS+k] = 1'b1;
                    eu_f[c0+LEVELS+k] = (k == 0);
                    eu_b[c0+LEVELS+k] = mn[w-1-k];
                    eu_r[c0+LEVELS+k] = tag;
                end
            end
        end
        for (int k = 0; k < w; k++) begin
            if (k > 0) @(negedge clk);
            for (int i = 0; i < LEAVES; i++) begin
                leaf_up_valid[i] = act[i];
                leaf_up_first[i] = act[i] && (k == 0);
                leaf_up_bit[i]   = act[i] && (msb ? vals[i][w-1-k] : vals[i][k]);
            end
        end
        @(negedge clk);
        leaf_up_valid = '0;
        leaf_up_first = '0;
        leaf_up_bit   = '0;
        repeat (gap - 1) @(negedge clk);
    endtask

    // Send one word on the root-down port; expect it at the leaves if mode 0
    task automatic send_down(input int w, input int unsigned pat, input string tag);
        int c0;
        @(negedge clk);
        c0 = cyc;
        if (mode == 2'd0) begin
            for (int k = 0; k < w; k++) begin
                ed_v[c0+LEVELS+k] = 1'b1;
                ed_f[c0+LEVELS+k] = (k == 0);
                ed_b[c0+LEVELS+k] = pat[k];
                ed_r[c0+LEVELS+k] = tag;
            end
        end
        for (int k = 0; k < w; k++) begin
            if (k > 0) @(negedge clk);
            root_down_valid = 1'b1;
            root_down_first = (k == 0);
            root_down_bit   = pat[k];
        end
        @(negedge clk);
        root_down_valid = 1'b0;
        root_down_first = 1'b0;
        root_down_bit   = 1'b0;
        repeat (LEVELS + 2) @(negedge clk);
    endtask

    initial begin
        clear_leaves();
        // R1: reset state
        repeat (2) @(negedge clk);
        checking = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: broadcast to all leaves, also R10 on the down marker
        idle_tag = "R2";
        send_down(6, 32'h2D, "R2");
        send_down(1, 32'h1, "R10");
        // R2: leaf-up traffic ignored in broadcast mode
        act[3] = 1'b1; vals[3] = 32'hA5;
        send_up(8, LEVELS + 3, "R2");
        clear_leaves();

        // R3: root-down input ignored outside broadcast mode
        idle_tag = "R3";
        set_mode(2'd2);
        send_down(5, 32'h1F, "R3");
        set_mode(2'd3);
        send_down(4, 32'h9, "R3");

        // R4: select mode
        idle_tag = "R4";
        set_mode(2'd1);
        act[5] = 1'b1; vals[5] = 32'h2D;
        send_up(8, LEVELS + 3, "R4");
        clear_leaves();
        act[0] = 1'b1; vals[0] = 32'hC3;
        send_up(8, LEVELS + 3, "R4");
        clear_leaves();
        act[7] = 1'b1; vals[7] = 32'h5;
        send_up(3, LEVELS + 3, "R10");
        clear_leaves();
        send_up(4, LEVELS + 3, "R4");

        // R5: sum mode, full carry growth and partial leaf sets
        idle_tag = "R5";
        set_mode(2'd2);
        for (int i = 0; i < LEAVES; i++) begin act[i] = 1'b1; vals[i] = 255; end
        send_up(8, LEVELS + 3, "R5");
        for (int i = 0; i < LEAVES; i++) vals[i] = 13 * i + 7;
        act[2] = 1'b0; act[6] = 1'b0;
        send_up(8, LEVELS + 3, "R5");
        clear_leaves();
        act[4] = 1'b1; vals[4] = 9;
        send_up(4, LEVELS + 3, "R5");

        // R6: population count of one-bit flags
        idle_tag = "R6";
        clear_leaves();
        for (int i = 0; i < LEAVES; i++) begin act[i] = 1'b1; vals[i] = (i % 3 != 1) ? 1 : 0; end
        send_up(1, LEVELS + 3, "R6");
        for (int i = 0; i < LEAVES; i++) vals[i] = 1;
        send_up(1, LEVELS + 3, "R6");

        // R7: back-to-back sum words with the minimum idle gap
        idle_tag = "R7";
        for (int i = 0; i < LEAVES; i++) vals[i] = 15;
        send_up(4, LEVELS, "R7");
        for (int i = 0; i < LEAVES; i++) vals[i] = i;
        send_up(4, LEVELS, "R7");
        for (int i = 0; i < LEAVES; i++) vals[i] = 0;
        send_up(4, LEVELS + 3, "R7");

        // R8: minimum, MSB first
        idle_tag = "R8";
        set_mode(2'd3);
        for (int i = 0; i < LEAVES; i++) begin act[i] = 1'b1; vals[i] = 200 - 17 * i; end
        send_up(8, LEVELS + 3, "R8");
        for (int i = 0; i < LEAVES; i++) vals[i] = 8'hB0 | (i ^ 5);
        send_up(8, LEVELS + 3, "R8");

        // R9: ties and idle leaves
        idle_tag = "R9";
        for (int i = 0; i < LEAVES; i++) vals[i] = 8'h6E;
        send_up(8, LEVELS + 3, "R9");
        clear_leaves();
        act[1] = 1'b1; vals[1] = 8'hF0;
        act[6] = 1'b1; vals[6] = 8'hF1;
        send_up(8, LEVELS + 3, "R9");
        clear_leaves();
        act[3] = 1'b1; vals[3] = 8'hFF;
        send_up(8, LEVELS + 3, "R9");
        clear_leaves();
        act[2] = 1'b1; vals[2] = 8'h44;
        act[3] = 1'b1; vals[3] = 8'h44;
        act[7] = 1'b1; vals[7] = 8'h45;
        send_up(8, LEVELS + 3, "R9");

        set_mode(2'd0);
        repeat (LEVELS + 3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule